// File: doc/BRIEF.md
# 8 kHz Reference Selector with Loss Monitor

This block drives a single 8 kHz reference line for the timing section of a telecom bus interface, and the line keeps running when the interface takes its timing from the bus. A two-bit field picks one of four sources for the reference:

- the bus frame pulse, passed through as is;
- an external 8 kHz pulse input, squared;
- a secondary 8 kHz pulse input, squared;
- a divided-down high-rate clock.

Both squared inputs go through a stage that toggles on each rising edge of the pulse. The divider path takes one of two high-rate clocks and counts its rising edges. A wide stage divides by a programmable ratio of 2 to 16384. A post stage then divides by 1, 2, 4 or 8 and emits a one-cycle pulse.

A supervisor watches the reference. It raises a free-run flag when no rising edge has appeared for a programmable number of system-clock cycles. All source inputs are sampled by the system clock through two-flop synchronisers. Any change to the selection or to the divider settings restarts the divider, so that no shortened period leaves the block.

Top module: `ref8k_select`

## Requirements
- R1: While rst_n is low, ref8k_out and freerun are both 0.
- R2: With ref_sel = 0, ref8k_out equals fsync_in as it was sampled three system-clock rising edges earlier.
- R3: With ref_sel = 1, ref8k_out is a square wave that toggles once for each rising edge of ext8k_in. The output appears three edges after the synchronised edge is detected. The squaring stages toggle whatever the selection.
- R4: With ref_sel = 2, ref8k_out is the squared form of sec8k_in, with the same rule as R3.
- R5: With ref_sel = 3, ref8k_out carries a one-cycle high pulse once every N x P rising edges of the chosen high-rate clock. N is the effective ratio and P is the post-divide factor.
- R6: The effective ratio N is div_ratio for values 2 to 16384. Values 0 and 1 act as 2, and values above 16384 act as 16384.
- R7: post_sel codes 0, 1, 2 and 3 set P to 1, 2, 4 and 8.
- R8: src_sel = 0 feeds the divider from hsclk_a, and src_sel = 1 feeds it from hsclk_b.
- R9: Any change in ref_sel, src_sel, div_ratio or post_sel clears both divider counts in the cycle it is seen. Counting then restarts from zero.
- R10: A rising edge on ref8k_out clears freerun and the cycle count. When timeout cycles have passed with no rising edge, freerun goes to 1. It stays at 1 until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync_in | input | 1 | Bus frame pulse |
| ext8k_in | input | 1 | External 8 kHz pulse |
| sec8k_in | input | 1 | Secondary 8 kHz pulse |
| hsclk_a | input | 1 | High-rate divider clock, choice 0 |
| hsclk_b | input | 1 | High-rate divider clock, choice 1 |
| ref_sel | input | 2 | Reference source: 0 frame, 1 external, 2 secondary, 3 divider |
| src_sel | input | 1 | Divider clock choice |
| div_ratio | input | 15 | Wide divider ratio (clamped, R6) |
| post_sel | input | 2 | Post-divide code |
| timeout | input | 16 | Free-run timeout in system-clock cycles |
| ref8k_out | output | 1 | Selected 8 kHz reference |
| freerun | output | 1 | Reference-absent flag |

## Verification
The frame path is driven with short pulses, so that the delay is seen directly. The external and secondary inputs run at different pulse periods, which shows whether the right squarer is routed to the output. The divider is run with both high-rate clocks, which have different periods. It is driven with small ratios under each post code, with the clamped values at both ends of the range, and with settings that change in the middle of a count. Each of these tells apart a wrong count length, a swapped source or a missed restart. For the monitor, the bench stops the reference and then starts it again, to show both the assertion after the timeout and the clearing on the next edge.

// File: rtl/ref8k_select.sv
`timescale 1ns/1ps
module ref8k_select #(
  parameter int MAX_RATIO = 16384,
  parameter int TOW       = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fsync_in,
  input  logic                          ext8k_in,
  input  logic                          sec8k_in,
  input  logic                          hsclk_a,
  input  logic                          hsclk_b,
  input  logic [1:0]                    ref_sel,
  input  logic                          src_sel,
  input  logic [$clog2(MAX_RATIO):0]    div_ratio,
  input  logic [1:0]                    post_sel,
  input  logic [TOW-1:0]                timeout,
  output logic                          ref8k_out,
  output logic                          freerun
);
  localparam int CW = $clog2(MAX_RATIO);
  localparam int RW = CW + 1;
  localparam int NI = 5;

  logic [NI-1:0] m1, m2, m3;
  wire  [NI-1:0] rise = m2 & ~m3;
  wire  hs_rise = src_sel ? rise[4] : rise[3];

  logic sq_ext, sq_sec, div_q, out_q;
  logic [CW-1:0]  cnt1;
  logic [2:0]     cnt2;
  logic [TOW-1:0] wd;
  logic [RW+4:0]  cfg_q;
  logic [RW-1:0]  n_eff;

  wire [RW+4:0] cfg = {src_sel, div_ratio, post_sel, ref_sel};
  wire          cfg_chg = (cfg != cfg_q);
  wire [2:0]    p_m1 = 3'((4'd1 << post_sel) - 4'd1);
  wire          ref_rise = ref8k_out & ~out_q;

  always_comb begin
    if (div_ratio < RW'(2))              n_eff = RW'(2);
    else if (div_ratio > RW'(MAX_RATIO)) n_eff = RW'(MAX_RATIO);
    else                                 n_eff = div_ratio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; m3 <= '0;
      sq_ext <= 1'b0; sq_sec <= 1'b0;
    end else begin
      m1 <= {hsclk_b, hsclk_a, sec8k_in, ext8k_in, fsync_in};
      m2 <= m1;
      m3 <= m2;
      if (rise[1]) sq_ext <= ~sq_ext;
      if (rise[2]) sq_sec <= ~sq_sec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt1 <= '0; cnt2 <= '0; div_q <= 1'b0; cfg_q <= '0;
    end else begin
      cfg_q <= cfg;
      div_q <= 1'b0;
      if (cfg_chg) begin
        cnt1 <= '0;
        cnt2 <= '0;
      end else if (hs_rise) begin
        if ({1'b0, cnt1} == n_eff - RW'(1)) begin
          cnt1 <= '0;
          if (cnt2 == p_m1) begin
            cnt2  <= '0;
            div_q <= 1'b1;
          end else cnt2 <= cnt2 + 3'd1;
        end else cnt1 <= cnt1 + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref8k_out <= 1'b0; out_q <= 1'b0; wd <= '0; freerun <= 1'b0;
    end else begin
      out_q <= ref8k_out;
      unique case (ref_sel)
        2'd0: ref8k_out <= m2[0];
        2'd1: ref8k_out <= sq_ext;
        2'd2: ref8k_out <= sq_sec;
        default: ref8k_out <= div_q;
      endcase
      if (ref_rise) begin
        wd <= '0;
        freerun <= 1'b0;
      end else if (wd == timeout) freerun <= 1'b1;
      else wd <= wd + TOW'(1);
    end
  end

  assert_sq_ext_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rise[1] |=> $stable(sq_ext));
  assert_sq_sec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rise[2] |=> $stable(sq_sec));
  assert_div_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_q |=> !div_q);
  assert_cnt1_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == cfg_q) |-> ({1'b0, cnt1} < n_eff));
  assert_cnt2_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == cfg_q) |-> (cnt2 <= p_m1));
  assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (cnt1 == '0 && cnt2 == '0 && !div_q));
  assert_edge_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !freerun);
  assert_fr_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freerun) |-> $past(wd) == $past(timeout));
endmodule

// File: tb/ref8k_select_bench.sv
`timescale 1ns/1ps
module ref8k_select_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fsync_in = 0, ext8k_in = 0, sec8k_in = 0, hsclk_a = 0, hsclk_b = 0;
  logic [1:0] ref_sel = 0, post_sel = 0;
  logic src_sel = 0;
  logic [14:0] div_ratio = 15'd3;
  logic [15:0] timeout = 16'hFFFF;
  logic ref8k_out, freerun;

  int checks = 0, fails = 0, cyc = 0;
  int fs_per = 0, ex_per = 0, se_per = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  ref8k_select u_ref8k_select (.clk, .rst_n, .fsync_in, .ext8k_in, .sec8k_in,
    .hsclk_a, .hsclk_b, .ref_sel, .src_sel, .div_ratio, .post_sel, .timeout,
    .ref8k_out, .freerun);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    fsync_in <= (fs_per != 0) && (cyc % (fs_per == 0 ? 1 : fs_per) < 2);
    ext8k_in <= (ex_per != 0) && (cyc % (ex_per == 0 ? 1 : ex_per) < 2);
    sec8k_in <= (se_per != 0) && (cyc % (se_per == 0 ? 1 : se_per) < 2);
    hsclk_a  <= (cyc % 4) < 2;
    hsclk_b  <= (cyc % 6) < 3;
  end

  // behavioural reference model
  bit qf[$], qe[$], qs[$], qa[$], qb[$];
  bit m_out = 0, m_oq = 0, m_fr = 0, m_sqe = 0, m_sqs = 0, m_dq = 0;
  int m_wd = 0, m_c1 = 0, m_c2 = 0;
  longint cfg_prev = 0;

  function automatic bit edge_of(ref bit q[$]);
    return q[2] && !q[3];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      qf = '{0,0,0,0}; qe = '{0,0,0,0}; qs = '{0,0,0,0}; qa = '{0,0,0,0}; qb = '{0,0,0,0};
      m_out = 0; m_oq = 0; m_fr = 0; m_sqe = 0; m_sqs = 0; m_dq = 0;
      m_wd = 0; m_c1 = 0; m_c2 = 0; cfg_prev = 0;
    end else begin
      longint cfg;
      bit ea, es, hr, nout, ndq, chg;
      int n, p;
      qf.push_front(fsync_in); void'(qf.pop_back());
      qe.push_front(ext8k_in); void'(qe.pop_back());
      qs.push_front(sec8k_in); void'(qs.pop_back());
      qa.push_front(hsclk_a);  void'(qa.pop_back());
      qb.push_front(hsclk_b);  void'(qb.pop_back());
      ea = edge_of(qe); es = edge_of(qs);
      hr = src_sel ? edge_of(qb) : edge_of(qa);
      cfg = {src_sel, div_ratio, post_sel, ref_sel};
      chg = (cfg != cfg_prev); cfg_prev = cfg;
      if (m_out && !m_oq) begin m_wd = 0; m_fr = 0; end
      else if (m_wd == int'(timeout)) m_fr = 1;
      else m_wd++;
      case (ref_sel)
        0: nout = qf[2];
        1: nout = m_sqe;
        2: nout = m_sqs;
        default: nout = m_dq;
      endcase
      m_oq = m_out; m_out = nout;
      if (ea) m_sqe = !m_sqe;
      if (es) m_sqs = !m_sqs;
      n = div_ratio < 2 ? 2 : (div_ratio > 16384 ? 16384 : int'(div_ratio));
      p = 1 << post_sel;
      ndq = 0;
      if (chg) begin m_c1 = 0; m_c2 = 0; end
      else if (hr) begin
        if (m_c1 == n - 1) begin
          m_c1 = 0;
          if (m_c2 == p - 1) begin m_c2 = 0; ndq = 1; end else m_c2++;
        end else m_c1++;
      end
      m_dq = ndq;
    end
  end

  task automatic check(bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    check(ref8k_out, m_out, "ref8k_out");
    check(freerun, m_fr, "freerun");
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(6);
    rst_n = 1'b1;
    cur_req = "R2"; fs_per = 40; ref_sel = 0; run(300);
    cur_req = "R3"; ex_per = 30; ref_sel = 1; run(300);
    cur_req = "R4"; se_per = 50; ref_sel = 2; run(400);
    cur_req = "R5"; ref_sel = 3; div_ratio = 3; post_sel = 0; run(300);
    cur_req = "R6"; div_ratio = 0; run(200);
    div_ratio = 1; run(200);
    cur_req = "R7";
    for (int i = 1; i < 4; i++) begin post_sel = 2'(i); div_ratio = 3; run(400); end
    cur_req = "R8"; src_sel = 1; post_sel = 1; div_ratio = 4; run(500);
    src_sel = 0; run(300);
    cur_req = "R9";
    for (int i = 0; i < 24; i++) begin
      div_ratio = (i % 2) ? 15'd5 : 15'd6;
      post_sel  = 2'(i % 3);
      run(37);
    end
    cur_req = "R6"; src_sel = 0; post_sel = 0; div_ratio = 15'd20000; run(70000);
    cur_req = "R10"; timeout = 16'd100; ref_sel = 1; div_ratio = 3; run(400);
    ex_per = 0; run(400);
    ex_per = 30; run(400);
    fs_per = 0; ref_sel = 0; run(300);
    fs_per = 40; run(300);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule